// File: doc/BRIEF.md
# Hardware Barrier Synchronizer

This unit lets a set of requesters meet at a common point before any of them goes on. Each requester raises its arrive line for one cycle and then waits. The unit counts arrivals in a shared counter. When the counter reaches the programmed number of participants, every requester that arrived in that episode is released in the same cycle. The counter then restarts from zero and an internal episode flag is set. The first arrival of the next episode clears the flag again.

Any number of requesters may arrive in the same cycle, and each one is counted. A released requester keeps its release line high until it arrives again, so a slow requester cannot miss the end of an episode. The arrival count can be summed as one flat adder chain, or as per-group partial sums that feed a root adder. A parameter chooses between the two, and they behave the same at the ports.

Top module: `barrier_sync_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, every release line is low and the arrival counter is empty.
- R2: After an arrival that does not complete the episode, that requester's release line is low until the episode completes.
- R3: In the cycle of the arrival that completes the count, every requester that arrived in the episode sees release high, including the final arrivers.
- R4: A requester's release line stays high until that requester's next arrive pulse, and drops in the cycle of that pulse unless the pulse itself completes an episode.
- R5: Arrivals in the same cycle are all counted, so an episode whose last participants arrive together completes in that cycle.
- R6: An arrive pulse from a requester that is already waiting is ignored and does not advance the count.
- R7: With a participant count of 1, or of 0 (treated as 1), an arriving requester is released in the same cycle it arrives.
- R8: A participant count above the number of requesters acts as the number of requesters.
- R9: A completed episode leaves the counter at zero with the episode flag set, and the first arrival of the next episode clears the flag. The next episode therefore needs the full participant count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| part_count | input | CNT_W | Number of participants per episode (0 acts as 1, above NUM_REQ acts as NUM_REQ) |
| arrive_i | input | NUM_REQ | One-cycle arrival pulse per requester |
| release_o | output | NUM_REQ | Per-requester release, held until that requester arrives again |

## Verification
The checker assumes that `part_count` changes only while the arrival counter is empty. It also assumes that arrive pulses last one cycle, and that a waiting requester re-pulses only in the ignored-arrival case. The stimulus changes the participant count only between completed episodes. It drives one arrive pattern per cycle and then returns the lines to zero. The duplicate pulse is issued on purpose while that requester is still waiting, so the ignore rule is exercised.

// File: rtl/barrier_sync_pkg.sv
package barrier_sync_pkg;
   typedef enum logic {
      SUM_FLAT = 1'b0,
      SUM_TREE = 1'b1
   } sum_kind_e;
endpackage

// File: rtl/barrier_arrival_sum.sv
module barrier_arrival_sum
   import barrier_sync_pkg::*;
#(
   parameter int        NUM_REQ    = 4,
   parameter int        GROUP_SIZE = 2,
   parameter int        CNT_W      = $clog2(NUM_REQ + 1),
   parameter sum_kind_e SUM_KIND   = SUM_TREE
) (
   input  logic [NUM_REQ-1:0] hits_i,
   output logic [CNT_W-1:0]   total_o
);
   localparam int NUM_GRP = (NUM_REQ + GROUP_SIZE - 1) / GROUP_SIZE;
   localparam int PAD_W   = NUM_GRP * GROUP_SIZE;

   generate
      if (SUM_KIND == SUM_FLAT) begin : g_flat
         always_comb begin
            total_o = '0;
            for (int k = 0; k < NUM_REQ; k++) begin
               total_o = total_o + CNT_W'(hits_i[k]);
            end
         end
      end else begin : g_tree
         logic [PAD_W-1:0] padded;
         logic [CNT_W-1:0] grp_sum [NUM_GRP];

         assign padded = PAD_W'(hits_i);

         for (genvar g = 0; g < NUM_GRP; g++) begin : g_leaf
            always_comb begin
               grp_sum[g] = '0;
               for (int k = 0; k < GROUP_SIZE; k++) begin
                  grp_sum[g] = grp_sum[g] + CNT_W'(padded[g*GROUP_SIZE + k]);
               end
            end
         end

         always_comb begin
            total_o = '0;
            for (int g = 0; g < NUM_GRP; g++) begin
               total_o = total_o + grp_sum[g];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/barrier_count_ctrl.sv
module barrier_count_ctrl #(
   parameter int NUM_REQ = 4,
   parameter int CNT_W   = $clog2(NUM_REQ + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] arr_sum_i,
   input  logic [CNT_W-1:0] need_i,
   output logic             fire_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic [CNT_W:0]   total;
   logic             any_arr;

   assign any_arr = (arr_sum_i != '0);
   assign total   = {1'b0, cnt_q} + {1'b0, arr_sum_i};
   assign fire_o  = any_arr && (total >= {1'b0, need_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (fire_o) begin
         cnt_q  <= '0;
         flag_q <= 1'b1;
      end else if (any_arr) begin
         cnt_q <= total[CNT_W-1:0];
         if (cnt_q == '0) begin
            flag_q <= 1'b0;
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/barrier_req_slot.sv
module barrier_req_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic arrive_i,
   input  logic fire_i,
   output logic take_o,
   output logic wait_o,
   output logic release_o
);
   logic wait_q;
   logic rel_q;
   logic joined;

   assign take_o    = arrive_i & ~wait_q;
   assign joined    = wait_q | take_o;
   assign release_o = (rel_q & ~arrive_i) | (fire_i & joined);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= 1'b0;
         rel_q  <= 1'b0;
      end else if (fire_i && joined) begin
         wait_q <= 1'b0;
         rel_q  <= 1'b1;
      end else if (take_o) begin
         wait_q <= 1'b1;
         rel_q  <= 1'b0;
      end
   end

   assign wait_o = wait_q;
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit
   import barrier_sync_pkg::*;
#(
   parameter int        NUM_REQ    = 4,
   parameter int        GROUP_SIZE = 2,
   parameter sum_kind_e SUM_KIND   = SUM_TREE,
   parameter int        CNT_W      = $clog2(NUM_REQ + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   part_count,
   input  logic [NUM_REQ-1:0] arrive_i,
   output logic [NUM_REQ-1:0] release_o
);
   generate
      if (NUM_REQ < 1) begin : g_bad_req
         $error("barrier_sync_unit: NUM_REQ must be at least 1");
      end
      if (GROUP_SIZE < 1) begin : g_bad_grp
         $error("barrier_sync_unit: GROUP_SIZE must be at least 1");
      end
      if (CNT_W < $clog2(NUM_REQ + 1)) begin : g_bad_cnt
         $error("barrier_sync_unit: CNT_W too narrow for NUM_REQ");
      end
   endgenerate

   logic [NUM_REQ-1:0] take_vec;
   logic [NUM_REQ-1:0] wait_vec;
   logic [CNT_W-1:0]   arr_sum;
   logic [CNT_W-1:0]   need;
   logic [CNT_W-1:0]   cnt;
   logic               fire;
   logic               flag;

   always_comb begin
      if (part_count == '0) begin
         need = CNT_W'(1);
      end else if (part_count > CNT_W'(NUM_REQ)) begin
         need = CNT_W'(NUM_REQ);
      end else begin
         need = part_count;
      end
   end

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
      barrier_req_slot slot_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .arrive_i  (arrive_i[i]),
         .fire_i    (fire),
         .take_o    (take_vec[i]),
         .wait_o    (wait_vec[i]),
         .release_o (release_o[i])
      );
   end

   barrier_arrival_sum #(
      .NUM_REQ    (NUM_REQ),
      .GROUP_SIZE (GROUP_SIZE),
      .CNT_W      (CNT_W),
      .SUM_KIND   (SUM_KIND)
   ) sum_i (
      .hits_i  (take_vec),
      .total_o (arr_sum)
   );

   barrier_count_ctrl #(
      .NUM_REQ (NUM_REQ),
      .CNT_W   (CNT_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .arr_sum_i (arr_sum),
      .need_i    (need),
      .fire_o    (fire),
      .cnt_o     (cnt),
      .flag_o    (flag)
   );
endmodule

// File: rtl/barrier_sync_unit_chk.sv
module barrier_sync_unit_chk #(
   parameter int NUM_REQ = 4,
   parameter int CNT_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CNT_W-1:0]   part_count,
   input logic [NUM_REQ-1:0] arrive_i,
   input logic [NUM_REQ-1:0] release_o,
   input logic [NUM_REQ-1:0] wait_vec,
   input logic               fire,
   input logic [CNT_W-1:0]   cnt,
   input logic               flag
);
   // R4: a release that was not cancelled by an arrival persists
   assert_hold_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(release_o & ~arrive_i)) |=>
         (($past(release_o & ~arrive_i) & ~release_o & ~arrive_i) == '0));

   // R2: a waiting requester is never released outside a completion
   assert_waiter_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |-> ((wait_vec & release_o) == '0));

   // R7: a participant count of one or zero releases in the arrival cycle
   assert_unit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((part_count <= CNT_W'(1)) && (|(arrive_i & ~wait_vec))) |->
         ((arrive_i & ~wait_vec & ~release_o) == '0));

   // R9: completion empties the counter and raises the episode flag
   assert_fire_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> ((cnt == '0) && flag));

   // R9: the opening arrival of an episode lowers the flag
   assert_first_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == '0) && (|(arrive_i & ~wait_vec)) && !fire) |=> !flag);

   // R5: the counter never holds a full complement
   assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(NUM_REQ));
endmodule

bind barrier_sync_unit barrier_sync_unit_chk #(
   .NUM_REQ (NUM_REQ),
   .CNT_W   (CNT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .part_count (part_count),
   .arrive_i   (arrive_i),
   .release_o  (release_o),
   .wait_vec   (wait_vec),
   .fire       (fire),
   .cnt        (cnt),
   .flag       (flag)
);

// File: tb/barrier_sync_unit_tb_top.sv
`timescale 1ns/1ps
module barrier_sync_unit_tb_top;
   localparam int NREQ   = 4;
   localparam int CW     = 3;
   localparam int PERIOD = 20;

   typedef struct {
      logic [NREQ-1:0] exp;
      string           tag;
   } exp_item_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [CW-1:0]   part_count = '0;
   logic [NREQ-1:0] arrive = '0;
   logic [NREQ-1:0] release_w;

   exp_item_t exp_q [$];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   barrier_sync_unit #(
      .NUM_REQ    (NREQ),
      .GROUP_SIZE (2),
      .CNT_W      (CW)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .part_count (part_count),
      .arrive_i   (arrive),
      .release_o  (release_w)
   );

   task automatic step(input logic [CW-1:0] cnt_v, input logic [NREQ-1:0] a,
                       input logic [NREQ-1:0] e, input string tag);
      exp_item_t it;
      @(negedge clk);
      part_count = cnt_v;
      arrive     = a;
      it.exp = e;
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor: compares each cycle's release against the queued expectation
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            checks++;
            if (release_w !== it.exp) begin
               fails++;
               $display("FAIL %s: release=%b expected=%b", it.tag, release_w, it.exp);
            end
         end
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      #5;
      checks++;
      if (release_w !== '0) begin
         fails++;
         $display("FAIL R1 in reset: release=%b expected=0000", release_w);
      end
      @(negedge clk);
      rst_n = 1'b1;
      step(3'd4, 4'b0000, 4'b0000, "R1 after reset");

      // staggered arrivals, count 4 (R2, R3, R4)
      step(3'd4, 4'b0001, 4'b0000, "R2 first arrival");
      step(3'd4, 4'b0010, 4'b0000, "R2 second arrival");
      step(3'd4, 4'b0100, 4'b0000, "R2 third arrival");
      step(3'd4, 4'b1000, 4'b1111, "R3 final arrival");
      step(3'd4, 4'b0000, 4'b1111, "R4 hold 1");
      step(3'd4, 4'b0000, 4'b1111, "R4 hold 2");

      // simultaneous closing arrivals (R4 drop, R5)
      step(3'd4, 4'b0001, 4'b1110, "R4 own arrival drops release");
      step(3'd4, 4'b1110, 4'b1111, "R5 three together complete");
      step(3'd4, 4'b0000, 4'b1111, "R5 held after");

      // duplicate pulse while waiting (R6)
      step(3'd3, 4'b0001, 4'b1110, "R6 first");
      step(3'd3, 4'b0001, 4'b1110, "R6 duplicate ignored");
      step(3'd3, 4'b0010, 4'b1100, "R6 count not advanced");
      step(3'd3, 4'b0100, 4'b1111, "R6 completes on third distinct");
      step(3'd3, 4'b0000, 4'b1111, "R6 held");

      // counter restarts after completion (R9)
      step(3'd2, 4'b0001, 4'b1110, "R9 new episode from zero");
      step(3'd2, 4'b0010, 4'b1111, "R9 second completes");
      step(3'd2, 4'b0000, 4'b1111, "R9 held");

      // unit and zero participant counts (R7)
      step(3'd1, 4'b0100, 4'b1111, "R7 count one same cycle");
      step(3'd1, 4'b0000, 4'b1111, "R7 count one held");
      step(3'd0, 4'b1000, 4'b1111, "R7 count zero same cycle");
      step(3'd0, 4'b0000, 4'b1111, "R7 count zero held");

      // oversized count clamps to the requester total (R8)
      step(3'd7, 4'b0011, 4'b1100, "R8 two of four");
      step(3'd7, 4'b0000, 4'b1100, "R2 idle while waiting");
      step(3'd7, 4'b1100, 4'b1111, "R8 clamped completion");
      step(3'd7, 4'b0000, 4'b1111, "R8 held");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule